// File: doc/BRIEF.md
# Bad Line Detector with Processor Bus Stall

This block works out, cycle by cycle, whether the raster line now being drawn must reload its character pointers (a "bad line"). On such a line the video side needs 40 extra memory cycles. The block therefore takes the bus from the processor for a fixed window and marks each of the 40 cycles in which a character pointer is fetched. Its inputs come from the surrounding video timing: the current raster line, the cycle number within the line (counted from 1), the 3-bit vertical scroll value and the display-enable control bit.

Display enable only counts if it was seen at some moment during the arming line, raster line 48. A single-bit record holds that fact for the rest of the frame and is cleared on raster line 0. The decision is combinational on the current inputs and that record, so it is made again in every cycle. Changing the scroll value part way through a line therefore starts or cancels a bad line from the very cycle of the change.

Top module: `badline_stall`

## Requirements
- R1: A bad line is only reported while the raster line lies between 48 and 247, both ends included. Line 247 can qualify; lines 40 and 248 never do.
- R2: Inside that range, a line is bad only when raster bits [2:0] equal the 3-bit vertical scroll input.
- R3: Display enable asserted in any single cycle of line 48 arms bad lines for the rest of the frame, even if it is dropped afterwards. Line 48 itself is treated as armed from that cycle on. If display enable is never high during line 48, no line of that frame is bad.
- R4: The armed record is cleared on raster line 0. Enable seen in an earlier frame does not carry into a frame whose line 48 lacks it.
- R5: The condition is evaluated in every cycle. A change of the vertical scroll value in the middle of a line creates or removes the bad line from that cycle onward.
- R6: While bad_line is high, bus_avail is low in line cycles 12 to 54 inclusive. In every other cycle bus_avail is high.
- R7: fetch_strobe is high while bad_line is high in cycles 15 to 54 inclusive. A line that is bad for its whole length therefore gives exactly 40 strobes.
- R8: fetch_strobe is never high unless bus_avail is low. bus_avail drops 3 cycles before the first fetch cycle.
- R9: With a vertical scroll value of 0 and display enable held high, line 48 is the first bad line of the frame.
- R10: After reset, the armed record is clear. bad_line and fetch_strobe are low and bus_avail is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one edge per video cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| raster_line | input | 9 | Current raster line number |
| line_cycle | input | 7 | Cycle within the line, first cycle is 1 |
| vscroll | input | 3 | Vertical fine scroll value |
| display_en | input | 1 | Display enable control bit |
| bad_line | output | 1 | Current cycle belongs to a bad line |
| bus_avail | output | 1 | Bus available to processor; low requests a stall |
| fetch_strobe | output | 1 | Marks a character-pointer fetch cycle |

## Verification
The hardest state to reach from the ports is a frame where display enable is high in only one cycle of line 48. The bad line must then start part way through line 48 and continue after enable has been dropped. A related case is a frame that follows an armed frame but never sees enable on line 48, which exposes a record that is not cleared at line 0. The bench walks whole frames of timing. It uses per-frame patterns: a one-cycle enable pulse, enable only on line 48, enable everywhere except line 48, and a mid-line scroll change. Each cycle is compared with an arithmetic model, and strobes are counted per line.

// File: rtl/badline_pkg.sv
package badline_pkg;

  // Line number inside an inclusive window
  function automatic logic line_in_window(input logic [8:0] line,
                                          input logic [8:0] lo,
                                          input logic [8:0] hi);
    return (line >= lo) && (line <= hi);
  endfunction

  // Full bad line test on one cycle's view of the inputs
  function automatic logic is_bad_line(input logic [8:0] line,
                                       input logic [2:0] scroll,
                                       input logic       armed,
                                       input logic [8:0] lo,
                                       input logic [8:0] hi);
    return line_in_window(line, lo, hi) && (line[2:0] == scroll) && armed;
  endfunction

  // Cycle inside an inclusive cycle window
  function automatic logic cycle_in_window(input logic [6:0] cyc,
                                           input logic [6:0] lo,
                                           input logic [6:0] hi);
    return (cyc >= lo) && (cyc <= hi);
  endfunction

endpackage

// File: rtl/bl_arm_tracker.sv
module bl_arm_tracker #(
  parameter int LINE_W   = 9,
  parameter int ARM_LINE = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] raster_line,
  input  logic              display_en,
  output logic              armed_q,
  output logic              armed_now
);
  localparam logic [LINE_W-1:0] ArmLine = LINE_W'(ARM_LINE);

  logic on_arm_line;
  logic on_top_line;

  assign on_arm_line = (raster_line == ArmLine);
  assign on_top_line = (raster_line == '0);

  // The current cycle counts as seen already
  assign armed_now = armed_q || (on_arm_line && display_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            armed_q <= 1'b0;
    else if (on_top_line)  armed_q <= 1'b0;
    else if (armed_now)    armed_q <= 1'b1;
  end

  AST_ARM_CLEARED_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (raster_line == '0) |=> !armed_q); // R4
  AST_ARM_ONLY_FROM_ARM_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !((raster_line == ArmLine) && display_en)) |=> !armed_q); // R3

endmodule

// File: rtl/bl_condition.sv
module bl_condition #(
  parameter int LINE_W     = 9,
  parameter int FIRST_LINE = 48,
  parameter int LAST_LINE  = 247
) (
  input  logic [LINE_W-1:0] raster_line,
  input  logic [2:0]        vscroll,
  input  logic              armed_now,
  output logic              bad_line
);
  import badline_pkg::*;

  localparam logic [8:0] FirstLine = 9'(FIRST_LINE);
  localparam logic [8:0] LastLine  = 9'(LAST_LINE);

  assign bad_line = is_bad_line(9'(raster_line), vscroll, armed_now,
                                FirstLine, LastLine);

endmodule

// File: rtl/bl_stall_window.sv
module bl_stall_window #(
  parameter int CYC_W       = 7,
  parameter int FETCH_FIRST = 15,
  parameter int FETCH_COUNT = 40,
  parameter int BA_LEAD     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bad_line,
  input  logic [CYC_W-1:0] line_cycle,
  output logic             ba_low,
  output logic             fetch_strobe
);
  import badline_pkg::*;

  localparam int FETCH_LAST = FETCH_FIRST + FETCH_COUNT - 1;
  localparam int BA_FIRST   = FETCH_FIRST - BA_LEAD;
  localparam int CNT_W      = $clog2(FETCH_COUNT + 1) + 1;

  logic [CNT_W-1:0] strobe_cnt_q;

  assign ba_low       = bad_line && cycle_in_window(7'(line_cycle), 7'(BA_FIRST), 7'(FETCH_LAST));
  assign fetch_strobe = bad_line && cycle_in_window(7'(line_cycle), 7'(FETCH_FIRST), 7'(FETCH_LAST));

  // Per-line strobe tally, restarted at the first cycle of each line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         strobe_cnt_q <= '0;
    else if (line_cycle == CYC_W'(1))   strobe_cnt_q <= '0;
    else if (fetch_strobe)              strobe_cnt_q <= strobe_cnt_q + 1'b1;
  end

  AST_STROBE_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_strobe |-> (strobe_cnt_q < CNT_W'(FETCH_COUNT))); // R7
  AST_STROBE_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_strobe |-> ba_low); // R8
  AST_LEAD_BEFORE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ba_low && !fetch_strobe) |-> (line_cycle < CYC_W'(FETCH_FIRST))); // R8

endmodule

// File: rtl/badline_stall.sv
module badline_stall #(
  parameter int LINE_W      = 9,
  parameter int CYC_W       = 7,
  parameter int FIRST_LINE  = 48,
  parameter int LAST_LINE   = 247,
  parameter int FETCH_FIRST = 15,
  parameter int FETCH_COUNT = 40,
  parameter int BA_LEAD     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] raster_line,
  input  logic [CYC_W-1:0]  line_cycle,
  input  logic [2:0]        vscroll,
  input  logic              display_en,
  output logic              bad_line,
  output logic              bus_avail,
  output logic              fetch_strobe
);
  logic armed_q;
  logic armed_now;
  logic ba_low;

  bl_arm_tracker #(.LINE_W(LINE_W), .ARM_LINE(FIRST_LINE)) u_arm (
    .clk(clk), .rst_n(rst_n), .raster_line(raster_line),
    .display_en(display_en), .armed_q(armed_q), .armed_now(armed_now));

  bl_condition #(.LINE_W(LINE_W), .FIRST_LINE(FIRST_LINE), .LAST_LINE(LAST_LINE)) u_cond (
    .raster_line(raster_line), .vscroll(vscroll),
    .armed_now(armed_now), .bad_line(bad_line));

  bl_stall_window #(.CYC_W(CYC_W), .FETCH_FIRST(FETCH_FIRST),
                    .FETCH_COUNT(FETCH_COUNT), .BA_LEAD(BA_LEAD)) u_win (
    .clk(clk), .rst_n(rst_n), .bad_line(bad_line), .line_cycle(line_cycle),
    .ba_low(ba_low), .fetch_strobe(fetch_strobe));

  assign bus_avail = !ba_low;

  AST_BAD_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_line && (raster_line != LINE_W'(FIRST_LINE))) |-> armed_q); // R3
  AST_BAD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_line |-> (raster_line >= LINE_W'(FIRST_LINE) && raster_line <= LINE_W'(LAST_LINE))); // R1
  AST_STALL_ONLY_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_avail |-> bad_line); // R6

endmodule

// File: tb/badline_stall_tb.sv
module badline_stall_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] raster_line = '0;
  logic [6:0] line_cycle = 7'd1;
  logic [2:0] vscroll = '0;
  logic       display_en = 1'b0;
  logic       bad_line, bus_avail, fetch_strobe;

  int checks = 0;
  int errors = 0;
  bit armed_m = 1'b0;
  int strobes_seen = 0;
  int strobes_exp = 0;

  always #5 clk = ~clk;

  badline_stall u_dut (
    .clk(clk), .rst_n(rst_n), .raster_line(raster_line), .line_cycle(line_cycle),
    .vscroll(vscroll), .display_en(display_en), .bad_line(bad_line),
    .bus_avail(bus_avail), .fetch_strobe(fetch_strobe));

  task automatic chk(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s line=%0d cyc=%0d actual=%0d expected=%0d",
               req, what, raster_line, line_cycle, act, exp);
    end
  endtask

  function automatic bit model_bad(input int line, input int ys, input bit d, input bit armed);
    return (line >= 48) && (line <= 247) && ((line % 8) == ys) && (armed || (line == 48 && d));
  endfunction

  function automatic string bad_tag(input int fr, input int line);
    if (fr == 0 || fr == 1) return "R3";
    if (fr == 2) return "R4";
    if (fr == 6) return "R5";
    if (fr == 8 && line <= 56) return "R9";
    if (line < 48 || line > 247) return "R1";
    return "R2";
  endfunction

  task automatic step(input int fr, input int line, input int cyc, input int ys, input bit d);
    bit eb;
    bit eba;
    bit est;
    raster_line = 9'(line); line_cycle = 7'(cyc); vscroll = 3'(ys); display_en = d;
    @(negedge clk);
    eb  = model_bad(line, ys, d, armed_m);
    eba = eb && cyc >= 12 && cyc <= 54;
    est = eb && cyc >= 15 && cyc <= 54;
    chk(bad_line, eb, bad_tag(fr, line), "bad_line");
    chk(bus_avail, !eba, "R6", "bus_avail");
    chk(fetch_strobe, est, "R7", "fetch_strobe");
    if (fetch_strobe && bus_avail) chk(0, 1, "R8", "strobe_without_stall");
    strobes_seen += fetch_strobe;
    strobes_exp  += est;
    if (cyc == 63) begin
      chk(strobes_seen, strobes_exp, "R7", "strobes_per_line");
      strobes_seen = 0; strobes_exp = 0;
    end
    if (line == 0) armed_m = 1'b0;
    else if (line == 48 && d) armed_m = 1'b1;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (192000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state on raster line 0 (record clear shows as no bad line later)
    chk(bad_line, 0, "R10", "reset bad_line");
    chk(bus_avail, 1, "R10", "reset bus_avail");
    chk(fetch_strobe, 0, "R10", "reset fetch_strobe");
    rst_n = 1'b1;
    @(posedge clk); #1;
    for (int fr = 0; fr < 9; fr++) begin
      for (int line = 0; line < 250; line++) begin
        for (int cyc = 1; cyc <= 63; cyc++) begin
          int ys;
          bit d;
          ys = (fr < 8) ? fr : 0;
          if (fr == 6) ys = (cyc >= 30) ? 7 : 6;
          case (fr)
            0:       d = (line == 48 && cyc == 20);
            1:       d = (line == 48);
            2:       d = (line != 48);
            default: d = 1'b1;
          endcase
          step(fr, line, cyc, ys, d);
        end
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule